// File: doc/BRIEF.md
# Instruction-Fetch Execution Guard

This block sits in the read-data path between a CPU and its memories. It sees every access the CPU issues. For each access it is told whether it is an instruction fetch, and it receives the data the memory returned. When a fetch falls inside a forbidden region, the block returns the all-zero word instead of the memory data. The all-zero word is an illegal instruction, so the CPU traps. Data accesses and fetches from permitted addresses are handed back unchanged, one cycle later.

There are two forbidden regions:
- The 2 KiB firmware-private RAM window is always forbidden.
- Software may define one extra window with a first-address register and a last-address register. This window becomes forbidden once a control write sets the enable bit.

Enabling is permanent until reset. It also freezes both address registers, so code running later cannot reopen the window.

Top module: `fetch_guard`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0, `out_rdata` is 0 and the application window is disabled.
- R2: Every access presented with `acc_valid` high produces `out_valid` high on the following cycle. `out_valid` is low in the cycle after an idle input. `out_rdata` is registered.
- R3: A fetch (`acc_instr`=1) with an address from 0xD000_0000 to 0xD000_07FF inclusive returns 0x0000_0000, whether or not the application window is enabled.
- R4: Fetches at 0xCFFF_FFFC and at 0xD000_0800, just outside the firmware RAM window, return the memory data.
- R5: While the enable flag is clear, fetches inside the programmed application window return the memory data.
- R6: A write to control (`cfg_sel`=2) with bit 0 set enables the window. A fetch with first <= address <= last (unsigned) then returns 0x0000_0000. Addresses first-4 and last+4 return the memory data.
- R7: A control write with bit 0 clear does not enable the window. Once the window is enabled, a later control write of 0 does not disable it. Only reset clears the flag.
- R8: Once the window is enabled, writes to the first-address register (`cfg_sel`=0) and to the last-address register (`cfg_sel`=1) are ignored.
- R9: Data accesses (`acc_instr`=0) return the memory data at any address, including both forbidden regions.
- R10: A configuration write with `cfg_sel`=3 changes no register.
- R11: When first > last, the enabled application window blocks no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 first address, 1 last address, 2 control, 3 none |
| cfg_wdata | input | 32 | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_instr | input | 1 | The access is an instruction fetch |
| acc_addr | input | 32 | Byte address of the access |
| acc_rdata | input | 32 | Data returned by memory for the access |
| out_valid | output | 1 | Registered response valid |
| out_rdata | output | 32 | Registered data to the CPU, possibly substituted |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing;
- that firmware-RAM fetches and fetches inside an enabled window come back as the illegal word;
- that data accesses pass through;
- that the enable flag stays set once it is set;
- that the address registers hold still while the flag is set.

Only the bench scenarios can show the rest:
- the exact window edges on both sides;
- that writes issued after enabling are truly discarded, seen through later fetches;
- the effect of select code 3;
- the inverted-window case;
- that a clearing control write leaves the guard armed.

// File: rtl/xg_pkg.sv
package xg_pkg;
  typedef enum logic [1:0] {
    SEL_FIRST = 2'd0,
    SEL_LAST  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  localparam int unsigned CTRL_EN_BIT = 0;
endpackage

// File: rtl/xg_range_regs.sv
module xg_range_regs #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q,
  output logic              en_q
);
  import xg_pkg::*;

  cfg_sel_e sel_e;
  assign sel_e = cfg_sel_e'(sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= '0;
      last_q  <= '0;
      en_q    <= 1'b0;
    end else if (we) begin
      unique case (sel_e)
        SEL_FIRST: if (!en_q) first_q <= wdata[ADDR_W-1:0];
        SEL_LAST:  if (!en_q) last_q  <= wdata[ADDR_W-1:0];
        SEL_CTRL:  if (wdata[CTRL_EN_BIT]) en_q <= 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/xg_region_check.sv
module xg_region_check #(
  parameter int unsigned ADDR_W      = 32,
  parameter logic [31:0] FWRAM_BASE  = 32'hD000_0000,
  parameter int unsigned FWRAM_BYTES = 2048
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              instr,
  input  logic              en,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  output logic              block
);
  localparam logic [ADDR_W-1:0] FW_LO = FWRAM_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] FW_HI = FW_LO + ADDR_W'(FWRAM_BYTES - 1);
  localparam bit POW2 = (FWRAM_BYTES & (FWRAM_BYTES - 1)) == 0;

  logic fw_hit;
  logic app_hit;

  generate
    if (POW2) begin : g_mask
      localparam logic [ADDR_W-1:0] MASK = ~ADDR_W'(FWRAM_BYTES - 1);
      assign fw_hit = (addr & MASK) == (FW_LO & MASK);
    end else begin : g_cmp
      assign fw_hit = (addr >= FW_LO) && (addr <= FW_HI);
    end
  endgenerate

  assign app_hit = en && (addr >= first) && (addr <= last);
  assign block   = instr && (fw_hit || app_hit);
endmodule

// File: rtl/xg_substitute.sv
module xg_substitute #(
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] ILLEGAL = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              block,
  input  logic [DATA_W-1:0] rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_rdata <= '0;
    end else begin
      out_valid <= valid;
      if (valid) out_rdata <= block ? ILLEGAL[DATA_W-1:0] : rdata;
    end
  end
endmodule

// File: rtl/fetch_guard.sv
module fetch_guard #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter logic [31:0] FWRAM_BASE  = 32'hD000_0000,
  parameter int unsigned FWRAM_BYTES = 2048,
  parameter logic [31:0] ILLEGAL     = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic              acc_instr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_rdata,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_rdata
);
  logic [ADDR_W-1:0] win_first;
  logic [ADDR_W-1:0] win_last;
  logic              win_en;
  logic              block;

  xg_range_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .first_q(win_first), .last_q(win_last), .en_q(win_en)
  );

  xg_region_check #(
    .ADDR_W(ADDR_W), .FWRAM_BASE(FWRAM_BASE), .FWRAM_BYTES(FWRAM_BYTES)
  ) u_check (
    .addr(acc_addr), .instr(acc_instr), .en(win_en),
    .first(win_first), .last(win_last), .block(block)
  );

  xg_substitute #(.DATA_W(DATA_W), .ILLEGAL(ILLEGAL)) u_sub (
    .clk(clk), .rst(rst), .valid(acc_valid), .block(block),
    .rdata(acc_rdata), .out_valid(out_valid), .out_rdata(out_rdata)
  );
endmodule

// File: rtl/fetch_guard_chk.sv
module fetch_guard_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DATA_W      = 32,
  parameter logic [31:0] FWRAM_BASE  = 32'hD000_0000,
  parameter int unsigned FWRAM_BYTES = 2048,
  parameter logic [31:0] ILLEGAL     = 32'h0000_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_instr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_rdata,
  input logic              win_en,
  input logic [ADDR_W-1:0] win_first,
  input logic [ADDR_W-1:0] win_last
);
  localparam logic [ADDR_W-1:0] LO = FWRAM_BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] HI = LO + ADDR_W'(FWRAM_BYTES - 1);

  logic in_fw;
  assign in_fw = (acc_addr >= LO) && (acc_addr <= HI);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    acc_valid |=> out_valid);
  assert_idle_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !out_valid);
  assert_fwram_block_R3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_instr && in_fw) |=> out_rdata == ILLEGAL[DATA_W-1:0]);
  assert_app_block_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_instr && win_en && acc_addr >= win_first && acc_addr <= win_last)
    |=> out_rdata == ILLEGAL[DATA_W-1:0]);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    win_en |=> win_en);
  assert_locked_R8: assert property (@(posedge clk) disable iff (rst)
    win_en |=> ($stable(win_first) && $stable(win_last)));
  assert_data_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_instr) |=> out_rdata == $past(acc_rdata));
endmodule

bind fetch_guard fetch_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FWRAM_BASE(FWRAM_BASE),
  .FWRAM_BYTES(FWRAM_BYTES), .ILLEGAL(ILLEGAL)
) u_chk (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_instr(acc_instr),
  .acc_addr(acc_addr), .acc_rdata(acc_rdata), .out_valid(out_valid),
  .out_rdata(out_rdata), .win_en(win_en), .win_first(win_first),
  .win_last(win_last)
);

// File: tb/tb_fetch_guard.sv
module tb_fetch_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        acc_valid;
  logic        acc_instr;
  logic [31:0] acc_addr;
  logic [31:0] acc_rdata;
  logic        out_valid;
  logic [31:0] out_rdata;

  always #4 clk = ~clk;

  fetch_guard dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_instr(acc_instr),
    .acc_addr(acc_addr), .acc_rdata(acc_rdata), .out_valid(out_valid),
    .out_rdata(out_rdata)
  );

  typedef struct {
    logic [31:0] exp;
    int          req;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // blocked: expected illegal word; otherwise memory data returned
  task automatic access(input bit instr, input logic [31:0] a, input bit blocked,
                        input int req);
    item_t it;
    @(negedge clk);
    acc_valid = 1'b1; acc_instr = instr; acc_addr = a;
    acc_rdata = a ^ 32'h5A5A_1234;
    it.exp = blocked ? 32'h0 : (a ^ 32'h5A5A_1234);
    it.req = req;
    q.push_back(it);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // monitor: scoreboard pop on each response
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (q.size() == 0) check(1'b0, 2, 32'h1, 32'h0);
        else begin
          item_t it;
          it = q.pop_front();
          check(out_rdata === it.exp, it.req, out_rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    acc_valid = 0; acc_instr = 0; acc_addr = 0; acc_rdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_valid === 1'b0, 1, {31'b0, out_valid}, 32'h0);
    check(out_rdata === 32'h0, 1, out_rdata, 32'h0);
    // R2: idle gives no response
    @(negedge clk);
    check(out_valid === 1'b0, 2, {31'b0, out_valid}, 32'h0);

    // R3 firmware RAM, monitor disabled
    access(1, 32'hD000_0000, 1, 3);
    access(1, 32'hD000_0400, 1, 3);
    access(1, 32'hD000_07FC, 1, 3);
    // R4 just outside
    access(1, 32'hCFFF_FFFC, 0, 4);
    access(1, 32'hD000_0800, 0, 4);
    // R9 data accesses to firmware RAM pass
    access(0, 32'hD000_0100, 0, 9);

    // program window, not enabled: R5
    cfg(2'd0, 32'h4000_1000);
    cfg(2'd1, 32'h4000_1FFC);
    access(1, 32'h4000_1000, 0, 5);
    access(1, 32'h4000_1800, 0, 5);
    // R7 control write of 0 does not enable
    cfg(2'd2, 32'h0000_0000);
    access(1, 32'h4000_1800, 0, 7);
    // R10 select 3 changes nothing: window still at same place
    cfg(2'd3, 32'hFFFF_FFFF);
    // enable: R6
    cfg(2'd2, 32'h0000_0001);
    access(1, 32'h4000_1000, 1, 6);
    access(1, 32'h4000_1FFC, 1, 6);
    access(1, 32'h4000_1800, 1, 10);
    access(1, 32'h4000_0FFC, 0, 6);
    access(1, 32'h4000_2000, 0, 6);
    access(0, 32'h4000_1800, 0, 9);
    access(1, 32'hD000_0010, 1, 3);
    // R7 cannot disable
    cfg(2'd2, 32'h0000_0000);
    access(1, 32'h4000_1400, 1, 7);
    // R8 writes ignored after lock
    cfg(2'd0, 32'h0000_0000);
    cfg(2'd1, 32'hFFFF_FFFC);
    access(1, 32'h4000_0800, 0, 8);
    access(1, 32'h4000_2400, 0, 8);
    access(1, 32'h4000_1004, 1, 8);

    // R11 inverted window after fresh reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    // R1 enable clear after reset: window fetch passes
    access(1, 32'h4000_1800, 0, 1);
    cfg(2'd0, 32'h4000_2000);
    cfg(2'd1, 32'h4000_1000);
    cfg(2'd2, 32'h0000_0001);
    access(1, 32'h4000_1000, 0, 11);
    access(1, 32'h4000_1800, 0, 11);
    access(1, 32'h4000_2000, 0, 11);
    access(1, 32'hD000_0000, 1, 3);

    repeat (3) @(negedge clk);
    done = 1;
    check(q.size() == 0, 2, q.size(), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule